// File: doc/BRIEF.md
# Shared Storage Write Data Path

This block carries store data toward a word-addressed core memory. It has three possible writers: the processor's storage register and two banks of channel bus switches. Each writer is gated where its data leaves the source. The gated words then meet on a single 36-bit bus. That bus is a plain bitwise OR, so a source whose gate is off contributes all zeros.

The processor's word reaches the bus only during an execute cycle that also asks for a store. A channel bank's word reaches the bus only while that bank's gate input is high. A memory data register of twice the bus width captures the merged word on a one-cycle write strobe. The low bit of the storage address picks which half receives it, and the other half keeps its contents. When more than one source is gated in the same cycle, a conflict flag is raised, but the bus still shows the OR of every gated word.

Top module: `store_bus_path`

## Requirements
- R1: `bus_out` is the bitwise OR of the words of all sources that are gated in the current cycle. When no source is gated, it is zero.
- R2: The processor word takes part in `bus_out` only while both `cpu_exec_cycle` and `cpu_store_req` are high. Either one alone leaves it off the bus.
- R3: The word of channel bank A (or B) takes part in `bus_out` only while `chan_a_gate` (or `chan_b_gate`) is high.
- R4: `gate_conflict` is high in exactly those cycles in which two or more of the three source gates are active. The processor gate counts as active when both of its conditions hold.
- R5: A clock edge with `wr_strobe` high, `rst` low and `addr_lsb` = 0 loads `bus_out` into `mdr_q[35:0]` and leaves `mdr_q[71:36]` unchanged.
- R6: A clock edge with `wr_strobe` high, `rst` low and `addr_lsb` = 1 loads `bus_out` into `mdr_q[71:36]` and leaves `mdr_q[35:0]` unchanged.
- R7: A clock edge with `wr_strobe` low leaves all 72 bits of `mdr_q` unchanged, whatever the bus carries.
- R8: A clock edge with `rst` high clears all 72 bits of `mdr_q`, even when `wr_strobe` is also high.
- R9: While `gate_conflict` is high, `bus_out` still carries the OR of the gated words. A strobe in that cycle writes that OR word into the selected half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the data register |
| cpu_word | input | 36 | Processor storage register word |
| cpu_exec_cycle | input | 1 | Processor is in an execute cycle |
| cpu_store_req | input | 1 | Processor control requests a store |
| chan_a_word | input | 36 | Channel bank A bus switch word |
| chan_a_gate | input | 1 | Gate for channel bank A |
| chan_b_word | input | 36 | Channel bank B bus switch word |
| chan_b_gate | input | 1 | Gate for channel bank B |
| addr_lsb | input | 1 | Half select: 0 = bits 35:0, 1 = bits 71:36 |
| wr_strobe | input | 1 | One-cycle write strobe for the data register |
| bus_out | output | 36 | Merged storage bus |
| gate_conflict | output | 1 | More than one source gated this cycle |
| mdr_q | output | 72 | Memory data register contents |

## Verification
Two functions can land in the same cycle. The first pair is gate conflict detection and a half write: the bench gates the processor and a channel bank together, and also all three sources, in a strobe cycle. It then expects the flag to be high and the OR word to appear in the selected half, with the other half unchanged. The second pair is reset and a write strobe: the bench raises both in one cycle and expects the register to be cleared rather than loaded.

// File: rtl/store_bus_pkg.sv
package store_bus_pkg;

  localparam int unsigned MAX_SOURCES = 8;

  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } mdr_half_e;

  // Number of gates that are on, out of a vector of up to MAX_SOURCES.
  function automatic int unsigned active_count(input logic [MAX_SOURCES-1:0] g);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_SOURCES; i++) begin
      n += int'(g[i]);
    end
    return n;
  endfunction

  // The processor drives the bus only in a store execute cycle.
  function automatic logic cpu_store_gate(input logic exec_cycle,
                                          input logic store_req);
    return exec_cycle & store_req;
  endfunction

endpackage

// File: rtl/src_gate.sv
module src_gate #(
  parameter int unsigned WORD_W = 36
) (
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] gated
);

  // Isolation is done here at the source: bits are forced to zero when off.
  always_comb begin
    for (int b = 0; b < WORD_W; b++) begin
      gated[b] = word[b] & en;
    end
  end

endmodule

// File: rtl/or_merge.sv
module or_merge
  import store_bus_pkg::*;
#(
  parameter int unsigned WORD_W  = 36,
  parameter int unsigned SOURCES = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SOURCES-1:0]             gates,
  input  logic [SOURCES-1:0][WORD_W-1:0] gated_words,
  output logic [WORD_W-1:0]              bus,
  output logic                           conflict
);

  logic [SOURCES:0][WORD_W-1:0] acc;
  logic [MAX_SOURCES-1:0]       gates_wide;

  assign acc[0] = '0;

  genvar i;
  generate
    for (i = 0; i < SOURCES; i++) begin : g_or
      assign acc[i+1] = acc[i] | gated_words[i];

      // R1
      word_in_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (gated_words[i] & ~bus) == '0);
    end
  endgenerate

  assign bus        = acc[SOURCES];
  assign gates_wide = MAX_SOURCES'(gates);
  assign conflict   = (active_count(gates_wide) > 1);

  // R4
  single_no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gates) |-> !conflict);

  // R4
  multi_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    !$onehot0(gates) |-> conflict);

endmodule

// File: rtl/mdr_halves.sv
module mdr_halves
  import store_bus_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  mdr_half_e           half,
  input  logic [WORD_W-1:0]   din,
  output logic [2*WORD_W-1:0] q
);

  localparam int unsigned MDR_W = 2 * WORD_W;

  logic [1:0] half_load;

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      assign half_load[h] = wr && (half == mdr_half_e'(h));

      always_ff @(posedge clk) begin
        if (rst) begin
          q[h*WORD_W +: WORD_W] <= '0;
        end else if (half_load[h]) begin
          q[h*WORD_W +: WORD_W] <= din;
        end
      end
    end
  endgenerate

  // R5
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && half == HALF_LOW) |=>
      (q[WORD_W-1:0] == $past(din)) && (q[MDR_W-1:WORD_W] == $past(q[MDR_W-1:WORD_W])));

  // R6
  high_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && half == HALF_HIGH) |=>
      (q[MDR_W-1:WORD_W] == $past(din)) && (q[WORD_W-1:0] == $past(q[WORD_W-1:0])));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R5 R6: at most one half loads per edge
  one_half_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(half_load));

endmodule

// File: rtl/store_bus_path.sv
module store_bus_path
  import store_bus_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   cpu_word,
  input  logic                cpu_exec_cycle,
  input  logic                cpu_store_req,
  input  logic [WORD_W-1:0]   chan_a_word,
  input  logic                chan_a_gate,
  input  logic [WORD_W-1:0]   chan_b_word,
  input  logic                chan_b_gate,
  input  logic                addr_lsb,
  input  logic                wr_strobe,
  output logic [WORD_W-1:0]   bus_out,
  output logic                gate_conflict,
  output logic [2*WORD_W-1:0] mdr_q
);

  localparam int unsigned SOURCES = 3;
  localparam int unsigned SRC_CPU = 0;
  localparam int unsigned SRC_CHA = 1;
  localparam int unsigned SRC_CHB = 2;

  // Named events for the assertions
  logic                           cpu_gate_en;
  logic [SOURCES-1:0]             src_en;
  logic [SOURCES-1:0][WORD_W-1:0] src_word;
  logic [SOURCES-1:0][WORD_W-1:0] src_gated;
  mdr_half_e                      half_sel;

  assign cpu_gate_en       = cpu_store_gate(cpu_exec_cycle, cpu_store_req);
  assign src_en[SRC_CPU]   = cpu_gate_en;
  assign src_en[SRC_CHA]   = chan_a_gate;
  assign src_en[SRC_CHB]   = chan_b_gate;
  assign src_word[SRC_CPU] = cpu_word;
  assign src_word[SRC_CHA] = chan_a_word;
  assign src_word[SRC_CHB] = chan_b_word;
  assign half_sel          = mdr_half_e'(addr_lsb);

  genvar s;
  generate
    for (s = 0; s < SOURCES; s++) begin : g_src
      src_gate #(.WORD_W(WORD_W)) u_gate (
        .en    (src_en[s]),
        .word  (src_word[s]),
        .gated (src_gated[s])
      );
    end
  endgenerate

  or_merge #(.WORD_W(WORD_W), .SOURCES(SOURCES)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .gates       (src_en),
    .gated_words (src_gated),
    .bus         (bus_out),
    .conflict    (gate_conflict)
  );

  mdr_halves #(.WORD_W(WORD_W)) u_mdr (
    .clk  (clk),
    .rst  (rst),
    .wr   (wr_strobe),
    .half (half_sel),
    .din  (bus_out),
    .q    (mdr_q)
  );

  // R2
  cpu_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_exec_cycle && cpu_store_req) |-> bus_out == (src_gated[SRC_CHA] | src_gated[SRC_CHB]));

  // R3
  chan_a_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_a_gate |-> bus_out == (src_gated[SRC_CPU] | src_gated[SRC_CHB]));

  // R3
  chan_b_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_b_gate |-> bus_out == (src_gated[SRC_CPU] | src_gated[SRC_CHA]));

  // R9
  conflict_or_chk: assert property (@(posedge clk) disable iff (rst)
    gate_conflict |-> bus_out == (src_gated[SRC_CPU] | src_gated[SRC_CHA] | src_gated[SRC_CHB]));

endmodule

// File: tb/store_bus_path_test.sv
module store_bus_path_test;

  localparam int W = 36;

  typedef struct {
    logic [W-1:0]   bus;
    logic           conf;
    logic [2*W-1:0] mdr;
    string          tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst;
  logic [W-1:0]   cpu_word, chan_a_word, chan_b_word;
  logic           cpu_exec_cycle, cpu_store_req, chan_a_gate, chan_b_gate;
  logic           addr_lsb, wr_strobe;
  logic [W-1:0]   bus_out;
  logic           gate_conflict;
  logic [2*W-1:0] mdr_q;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  exp_t  sb[$];
  logic [2*W-1:0] model_mdr = '0;

  always #4 clk = ~clk;

  store_bus_path uut (
    .clk(clk), .rst(rst),
    .cpu_word(cpu_word), .cpu_exec_cycle(cpu_exec_cycle), .cpu_store_req(cpu_store_req),
    .chan_a_word(chan_a_word), .chan_a_gate(chan_a_gate),
    .chan_b_word(chan_b_word), .chan_b_gate(chan_b_gate),
    .addr_lsb(addr_lsb), .wr_strobe(wr_strobe),
    .bus_out(bus_out), .gate_conflict(gate_conflict), .mdr_q(mdr_q)
  );

  // Driver: drive at the falling edge and push what the next rising edge should show.
  task automatic drive(input logic r, input logic [W-1:0] cw, input logic ex, input logic st,
                       input logic [W-1:0] aw, input logic ag,
                       input logic [W-1:0] bw, input logic bg,
                       input logic sel, input logic wr, input string tag);
    exp_t e;
    int   n;
    @(negedge clk);
    rst = r; cpu_word = cw; cpu_exec_cycle = ex; cpu_store_req = st;
    chan_a_word = aw; chan_a_gate = ag; chan_b_word = bw; chan_b_gate = bg;
    addr_lsb = sel; wr_strobe = wr;
    e.bus = '0;
    n = 0;
    if (ex && st) begin e.bus = e.bus | cw; n++; end
    if (ag)       begin e.bus = e.bus | aw; n++; end
    if (bg)       begin e.bus = e.bus | bw; n++; end
    e.conf = (n >= 2);
    if (r)             model_mdr = '0;
    else if (wr && sel) model_mdr = {e.bus, model_mdr[W-1:0]};
    else if (wr)        model_mdr = {model_mdr[2*W-1:W], e.bus};
    e.mdr = model_mdr;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: after each rising edge, compare against the oldest expected item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks += 3;
        if (bus_out !== e.bus) begin
          failures++;
          $display("FAIL %s bus_out actual=%h expected=%h", e.tag, bus_out, e.bus);
        end
        if (gate_conflict !== e.conf) begin
          failures++;
          $display("FAIL %s gate_conflict actual=%b expected=%b", e.tag, gate_conflict, e.conf);
        end
        if (mdr_q !== e.mdr) begin
          failures++;
          $display("FAIL %s mdr_q actual=%h expected=%h", e.tag, mdr_q, e.mdr);
        end
      end
    end
  end

  localparam logic [W-1:0] CW = 36'h800000001;
  localparam logic [W-1:0] AW = 36'h0F0F0F0F0;
  localparam logic [W-1:0] BW = 36'h123456789;

  initial begin
    rst = 1'b1; cpu_word = '0; cpu_exec_cycle = 0; cpu_store_req = 0;
    chan_a_word = '0; chan_a_gate = 0; chan_b_word = '0; chan_b_gate = 0;
    addr_lsb = 0; wr_strobe = 0;
    // R8 reset state, reset wins over a strobe
    drive(1, CW, 1, 1, '0, 0, '0, 0, 0, 1, "R8 reset");
    drive(1, '0, 0, 0, '0, 0, '0, 0, 0, 0, "R8 reset idle");
    // R1 nothing gated -> zero bus
    drive(0, CW, 0, 0, AW, 0, BW, 0, 0, 0, "R1 idle");
    // R2 processor gating
    drive(0, CW, 1, 1, AW, 0, BW, 0, 0, 1, "R2 cpu store low");
    drive(0, CW, 1, 0, '0, 0, '0, 0, 1, 0, "R2 exec only");
    drive(0, CW, 0, 1, '0, 0, '0, 0, 1, 0, "R2 store only");
    // R3 channel gating
    drive(0, CW, 0, 1, AW, 1, BW, 0, 1, 1, "R3 chan A high");
    drive(0, CW, 1, 0, AW, 0, BW, 1, 0, 1, "R3 chan B low");
    // R4 R9 conflicts with writes
    drive(0, CW, 1, 1, AW, 1, BW, 0, 1, 1, "R4 R9 cpu+A high");
    drive(0, CW, 1, 1, AW, 1, BW, 1, 0, 1, "R4 R9 all low");
    drive(0, CW, 0, 0, AW, 1, BW, 1, 1, 0, "R4 A+B no write");
    // R5 R6 fresh half writes
    drive(0, 36'hFFFFFFFFF, 1, 1, '0, 0, '0, 0, 0, 1, "R5 low all ones");
    drive(0, '0, 0, 0, 36'h000000002, 1, '0, 0, 1, 1, "R6 high word");
    // R7 strobe low, data on bus
    drive(0, CW, 1, 1, AW, 1, BW, 1, 0, 0, "R7 hold");
    drive(0, CW, 1, 1, AW, 0, BW, 0, 1, 0, "R7 hold high sel");
    // R8 mid-run reset with strobe
    drive(0, '0, 0, 0, '0, 0, BW, 1, 1, 1, "R6 before reset");
    drive(1, CW, 1, 1, AW, 1, BW, 1, 1, 1, "R8 reset with strobe");
    drive(0, '0, 0, 0, '0, 0, '0, 0, 0, 0, "R1 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule